// File: doc/BRIEF.md
# Framed Dual-Clock Codec Serial Port

This block is the serial front end of a per-channel speech transcoder. Two externally clocked serial links feed it: a PCM link that carries 8-bit companded samples, and an ADPCM link that carries 4- or 5-bit difference codes. A single framing signal, `frame_en`, opens a transfer window. A direction input, `dir_tx`, picks the path for that window. When it is high, the window is a transmit step: a PCM word comes in and an ADPCM code goes out. When it is low, the window is a receive step: an ADPCM code comes in and a PCM word goes out.

When the window closes on the falling edge of `frame_en`, the block freezes the captured word. It freezes along with it the per-channel control inputs: the quantizer select, the coding law, the channel enable and the channel initialize. A toggle handshake carries this record into the asynchronous master clock domain, where the core sees it as a one-cycle `core_valid` pulse. The core hands back its result through `res_valid`. During the next window of the same direction, the block shifts that result out on the matching serial output. Each output is given as a data bit plus an output-enable that the pad ring uses for tri-stating.

Top module: `codec_serial_port`

## Requirements
- R1: On each falling edge of `pcm_sclk` while `frame_en` and `dir_tx` are both high, `pcm_sdi` is shifted into the PCM capture register. A transmit capture delivers the last 8 such bits in `core_word`, with the first-received bit at bit 7.
- R2: On each falling edge of `adp_sclk` while `frame_en` is high and `dir_tx` is low, `adp_sdi` is shifted into the ADPCM capture register. A receive capture delivers the last N bits right-aligned in `core_word`, first-received bit most significant, with the upper bits zero. N is 5 when `qsel` is 2'b11 and 4 otherwise.
- R3: Serial clock edges that arrive while `frame_en` is low have no effect on any captured word. Edges on the clock of the path that the current direction does not select also have no effect.
- R4: `qsel`, `law_a` (0 = mu-law, 1 = A-law with even-bit inversion), `chan_en`, `chan_init` and `dir_tx` are sampled only at the falling edge of `frame_en`. They are presented on the `core_*` outputs together with the word, and `core_word` changes only in a cycle where `core_valid` is high.
- R5: Each falling edge of `frame_en` produces exactly one `core_valid` pulse in the `clk` domain, one cycle wide.
- R6: While reset is asserted and after it is released, `core_valid`, `adp_sdo_oe` and `pcm_sdo_oe` are low.
- R7: `adp_sdo_oe` is high exactly while `frame_en` and `dir_tx` are high and a transmit result is pending. `adp_sdo` presents the result's N bits MSB first, advancing one bit on each rising edge of `adp_sclk`. N comes from the quantizer select of the transmit capture that produced the result.
- R8: `pcm_sdo_oe` is high exactly while `frame_en` is high, `dir_tx` is low and a receive result is pending. `pcm_sdo` presents the 8 result bits MSB first, advancing one bit on each rising edge of `pcm_sclk`.
- R9: `adp_sdo_oe` and `pcm_sdo_oe` are never high together. Both are low whenever `frame_en` is low.
- R10: A result stays pending until the next capture of its own direction reaches the core. A window that starts after that capture drives no output unless a new result has been returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, asynchronous to both serial clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_en | input | 1 | Transfer window; falling edge latches word and controls |
| dir_tx | input | 1 | 1 = transmit step, 0 = receive step; stable while window open |
| qsel | input | 2 | Quantizer select; 2'b11 selects 5-bit ADPCM codes |
| law_a | input | 1 | Coding law: 0 mu-law, 1 A-law |
| chan_en | input | 1 | Channel active flag |
| chan_init | input | 1 | Channel initialize request |
| pcm_sclk | input | 1 | PCM serial clock |
| pcm_sdi | input | 1 | PCM serial data in (transmit path) |
| pcm_sdo | output | 1 | PCM serial data out (receive result) |
| pcm_sdo_oe | output | 1 | Output enable for pcm_sdo |
| adp_sclk | input | 1 | ADPCM serial clock |
| adp_sdi | input | 1 | ADPCM serial data in (receive path) |
| adp_sdo | output | 1 | ADPCM serial data out (transmit result) |
| adp_sdo_oe | output | 1 | Output enable for adp_sdo |
| core_valid | output | 1 | One-cycle pulse: a new captured record is on core_* |
| core_dir_tx | output | 1 | Direction of the captured record |
| core_qsel | output | 2 | Captured quantizer select |
| core_law_a | output | 1 | Captured coding law |
| core_chan_en | output | 1 | Captured channel enable |
| core_chan_init | output | 1 | Captured channel initialize |
| core_word | output | 8 | Captured PCM word or right-aligned ADPCM code |
| res_valid | input | 1 | Core returns a result this cycle |
| res_dir_tx | input | 1 | Direction of the returned result |
| res_word | input | 8 | Result: ADPCM code in low bits, or PCM word |

## Verification
The bench keeps a history of every bit that should have been shifted in, including windows that carry fewer clock edges than a full word. A design that resets its capture register at each window, or that keeps the wrong N bits, then delivers a word built from the wrong history. Junk clock edges outside the window and on the path not selected would corrupt that history in a design that ignored the gating. The controls are changed right after each window closes, so a design that samples them late reports values that were never framed. Windows run both with and without a pending result, so the bench catches an output enable that depends on direction but not on the pending flag, or one that fails to drop after the next same-direction capture.

// File: rtl/codec_sp_pkg.sv
package codec_sp_pkg;
  localparam int PCM_W     = 8;
  localparam int ADP_W_MAX = 5;

  typedef struct packed {
    logic             dir_tx;
    logic [1:0]       qsel;
    logic             law_a;
    logic             chan_en;
    logic             chan_init;
    logic [PCM_W-1:0] word;
  } frame_rec_t;

  // ADPCM code length selected by the quantizer field
  function automatic logic [3:0] adp_len(input logic [1:0] q);
    return (q == 2'b11) ? 4'd5 : 4'd4;
  endfunction

  // Keep the most recent adp_len(q) bits, right aligned, zero above
  function automatic logic [PCM_W-1:0] adp_trim(input logic [ADP_W_MAX-1:0] sr,
                                                input logic [1:0] q);
    logic [ADP_W_MAX-1:0] mask;
    mask = (q == 2'b11) ? {ADP_W_MAX{1'b1}} : {1'b0, {(ADP_W_MAX-1){1'b1}}};
    return PCM_W'(sr & mask);
  endfunction
endpackage

// File: rtl/cs_shift_in.sv
module cs_shift_in #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         frame_en,
  input  logic         path_sel,
  input  logic         sdi,
  output logic [W-1:0] sr
);
  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n)                    sr <= '0;
    else if (frame_en && path_sel) sr <= {sr[W-2:0], sdi};
  end
endmodule

// File: rtl/cs_frame_latch.sv
module cs_frame_latch
  import codec_sp_pkg::*;
#(
  parameter int PW = PCM_W,
  parameter int AW = ADP_W_MAX
) (
  input  logic          rst_n,
  input  logic          frame_en,
  input  logic          dir_tx,
  input  logic [1:0]    qsel,
  input  logic          law_a,
  input  logic          chan_en,
  input  logic          chan_init,
  input  logic [PW-1:0] pcm_sr,
  input  logic [AW-1:0] adp_sr,
  output frame_rec_t    rec,
  output logic          tog
);
  frame_rec_t nxt;

  always_comb begin
    nxt.dir_tx    = dir_tx;
    nxt.qsel      = qsel;
    nxt.law_a     = law_a;
    nxt.chan_en   = chan_en;
    nxt.chan_init = chan_init;
    nxt.word      = dir_tx ? pcm_sr : adp_trim(adp_sr, qsel);
  end

  always_ff @(negedge frame_en or negedge rst_n) begin
    if (!rst_n) begin
      rec <= '0;
      tog <= 1'b0;
    end else begin
      rec <= nxt;
      tog <= ~tog;
    end
  end
endmodule

// File: rtl/cs_cdc_handoff.sv
module cs_cdc_handoff #(
  parameter int W      = 14,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tog_in,
  input  logic [W-1:0] din,
  output logic         pulse,
  output logic         dvalid,
  output logic [W-1:0] dout
);
  logic [STAGES:0] sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[STAGES-1:0], tog_in};
  end

  assign pulse = sync[STAGES] ^ sync[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvalid <= 1'b0;
      dout   <= '0;
    end else begin
      dvalid <= pulse;
      if (pulse) dout <= din;
    end
  end
endmodule

// File: rtl/cs_shift_out.sv
module cs_shift_out #(
  parameter int W_MAX = 8,
  localparam int IW   = $clog2(W_MAX + 1)
) (
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             frame_en,
  input  logic             active,
  input  logic [W_MAX-1:0] word,
  input  logic [IW-1:0]    len,
  output logic             sdo,
  output logic             oe
);
  logic [IW-1:0]    idx;
  logic [IW-1:0]    pos;
  logic [W_MAX-1:0] shifted;

  always_ff @(posedge sclk or negedge rst_n or negedge frame_en) begin
    if (!rst_n || !frame_en) idx <= '0;
    else if (idx < len)      idx <= idx + IW'(1);
  end

  always_comb begin
    pos     = len - idx - IW'(1);
    shifted = word >> pos;
    sdo     = (idx < len) ? shifted[0] : 1'b0;
  end

  assign oe = frame_en & active;
endmodule

// File: rtl/codec_serial_port.sv
module codec_serial_port
  import codec_sp_pkg::*;
#(
  parameter int PW = PCM_W,
  parameter int AW = ADP_W_MAX,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_en,
  input  logic          dir_tx,
  input  logic [1:0]    qsel,
  input  logic          law_a,
  input  logic          chan_en,
  input  logic          chan_init,
  input  logic          pcm_sclk,
  input  logic          pcm_sdi,
  output logic          pcm_sdo,
  output logic          pcm_sdo_oe,
  input  logic          adp_sclk,
  input  logic          adp_sdi,
  output logic          adp_sdo,
  output logic          adp_sdo_oe,
  output logic          core_valid,
  output logic          core_dir_tx,
  output logic [1:0]    core_qsel,
  output logic          core_law_a,
  output logic          core_chan_en,
  output logic          core_chan_init,
  output logic [PW-1:0] core_word,
  input  logic          res_valid,
  input  logic          res_dir_tx,
  input  logic [PW-1:0] res_word
);
  localparam int REC_W  = $bits(frame_rec_t);
  localparam int PCM_IW = $clog2(PW + 1);
  localparam int ADP_IW = $clog2(AW + 1);

  logic [PW-1:0] pcm_sr;
  logic [AW-1:0] adp_sr;
  frame_rec_t    rec_frame;
  frame_rec_t    rec_core;
  logic          rec_tog;
  logic          cap_pulse;   // named event: capture seen in clk domain

  // capture paths
  cs_shift_in #(.W(PW)) u_pcm_in (
    .rst_n(rst_n), .sclk(pcm_sclk), .frame_en(frame_en),
    .path_sel(dir_tx), .sdi(pcm_sdi), .sr(pcm_sr));

  cs_shift_in #(.W(AW)) u_adp_in (
    .rst_n(rst_n), .sclk(adp_sclk), .frame_en(frame_en),
    .path_sel(~dir_tx), .sdi(adp_sdi), .sr(adp_sr));

  cs_frame_latch #(.PW(PW), .AW(AW)) u_latch (
    .rst_n(rst_n), .frame_en(frame_en), .dir_tx(dir_tx), .qsel(qsel),
    .law_a(law_a), .chan_en(chan_en), .chan_init(chan_init),
    .pcm_sr(pcm_sr), .adp_sr(adp_sr), .rec(rec_frame), .tog(rec_tog));

  cs_cdc_handoff #(.W(REC_W), .STAGES(SYNC_STAGES)) u_cdc (
    .clk(clk), .rst_n(rst_n), .tog_in(rec_tog), .din(rec_frame),
    .pulse(cap_pulse), .dvalid(core_valid), .dout(rec_core));

  assign core_dir_tx    = rec_core.dir_tx;
  assign core_qsel      = rec_core.qsel;
  assign core_law_a     = rec_core.law_a;
  assign core_chan_en   = rec_core.chan_en;
  assign core_chan_init = rec_core.chan_init;
  assign core_word      = rec_core.word;

  // result holding in the master domain
  logic          tx_pend, rx_pend;
  logic [AW-1:0] tx_res;
  logic [PW-1:0] rx_res;
  logic [1:0]    tx_qsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pend <= 1'b0;
      rx_pend <= 1'b0;
      tx_res  <= '0;
      rx_res  <= '0;
      tx_qsel <= '0;
    end else begin
      if (core_valid) begin
        if (core_dir_tx) begin
          tx_pend <= 1'b0;
          tx_qsel <= core_qsel;
        end else begin
          rx_pend <= 1'b0;
        end
      end
      if (res_valid) begin
        if (res_dir_tx) begin
          tx_pend <= 1'b1;
          tx_res  <= res_word[AW-1:0];
        end else begin
          rx_pend <= 1'b1;
          rx_res  <= res_word;
        end
      end
    end
  end

  logic [ADP_IW-1:0] tx_len;
  assign tx_len = ADP_IW'(adp_len(tx_qsel));

  // result shifters
  cs_shift_out #(.W_MAX(AW)) u_adp_out (
    .rst_n(rst_n), .sclk(adp_sclk), .frame_en(frame_en),
    .active(dir_tx & tx_pend), .word(tx_res), .len(tx_len),
    .sdo(adp_sdo), .oe(adp_sdo_oe));

  cs_shift_out #(.W_MAX(PW)) u_pcm_out (
    .rst_n(rst_n), .sclk(pcm_sclk), .frame_en(frame_en),
    .active(~dir_tx & rx_pend), .word(rx_res), .len(PCM_IW'(PW)),
    .sdo(pcm_sdo), .oe(pcm_sdo_oe));
endmodule

// File: rtl/codec_sp_checker.sv
module codec_sp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_en,
  input logic       dir_tx,
  input logic       adp_sdo_oe,
  input logic       pcm_sdo_oe,
  input logic       core_valid,
  input logic [7:0] core_word,
  input logic       cap_pulse
);
  p_valid_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_valid |=> !core_valid);

  p_pulse_gives_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |=> core_valid);

  p_word_moves_with_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(core_word) |-> core_valid);

  p_adp_oe_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adp_sdo_oe |-> (frame_en && dir_tx));

  p_pcm_oe_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_sdo_oe |-> (frame_en && !dir_tx));

  p_oe_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(adp_sdo_oe && pcm_sdo_oe));
endmodule

bind codec_serial_port codec_sp_checker chk_i (
  .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .dir_tx(dir_tx),
  .adp_sdo_oe(adp_sdo_oe), .pcm_sdo_oe(pcm_sdo_oe),
  .core_valid(core_valid), .core_word(core_word), .cap_pulse(cap_pulse));

// File: tb/codec_serial_port_tb.sv
module codec_serial_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 23;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_en = 1'b0, dir_tx = 1'b0;
  logic [1:0] qsel = '0;
  logic       law_a = 1'b0, chan_en = 1'b0, chan_init = 1'b0;
  logic       pcm_sclk = 1'b1, pcm_sdi = 1'b0, adp_sclk = 1'b1, adp_sdi = 1'b0;
  logic       res_valid = 1'b0, res_dir_tx = 1'b0;
  logic [7:0] res_word = '0;
  logic       pcm_sdo, pcm_sdo_oe, adp_sdo, adp_sdo_oe;
  logic       core_valid, core_dir_tx, core_law_a, core_chan_en, core_chan_init;
  logic [1:0] core_qsel;
  logic [7:0] core_word;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // model state
  logic [7:0] pcm_hist = '0, adp_hist = '0;
  bit         m_tx_pend = 0, m_rx_pend = 0;
  logic [4:0] m_tx_res = '0;
  logic [7:0] m_rx_res = '0;
  logic [1:0] m_tx_q = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .dir_tx(dir_tx),
    .qsel(qsel), .law_a(law_a), .chan_en(chan_en), .chan_init(chan_init),
    .pcm_sclk(pcm_sclk), .pcm_sdi(pcm_sdi), .pcm_sdo(pcm_sdo), .pcm_sdo_oe(pcm_sdo_oe),
    .adp_sclk(adp_sclk), .adp_sdi(adp_sdi), .adp_sdo(adp_sdo), .adp_sdo_oe(adp_sdo_oe),
    .core_valid(core_valid), .core_dir_tx(core_dir_tx), .core_qsel(core_qsel),
    .core_law_a(core_law_a), .core_chan_en(core_chan_en), .core_chan_init(core_chan_init),
    .core_word(core_word), .res_valid(res_valid), .res_dir_tx(res_dir_tx),
    .res_word(res_word));

  function automatic int code_len(input logic [1:0] q);
    return (q == 2'b11) ? 5 : 4;
  endfunction

  function automatic logic [7:0] last_bits(input logic [7:0] h, input int n);
    return h & 8'((1 << n) - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  // junk serial activity with the window closed (R3)
  task automatic junk_edges();
    int n = $urandom_range(0, 3);
    for (int k = 0; k < n; k++) begin
      pcm_sdi = 1'($urandom); adp_sdi = 1'($urandom);
      pcm_sclk = 1'b0; adp_sclk = 1'b0; #HALF;
      pcm_sclk = 1'b1; adp_sclk = 1'b1; #HALF;
    end
  endtask

  // force_q < 0 picks random; force_n < 0 picks random input edge count
  task automatic run_window(input bit tx, input int force_q, input int force_n,
                            input bit give_result);
    logic [1:0] q;
    logic       l, e, ini;
    int         steps, n_in, olen, found;
    bit         active;
    logic [7:0] oword, exp_word, w;
    q   = (force_q < 0) ? 2'($urandom) : 2'(force_q);
    l   = 1'($urandom); e = 1'($urandom); ini = 1'($urandom);
    steps = tx ? 10 : 8;
    if (force_n >= 0)              n_in = force_n;
    else if ($urandom % 3 != 0)    n_in = tx ? 8 : code_len(q);
    else                           n_in = $urandom_range(0, steps);
    active = tx ? m_tx_pend : m_rx_pend;
    olen   = tx ? code_len(m_tx_q) : 8;
    oword  = tx ? 8'(m_tx_res) : m_rx_res;

    dir_tx = tx; #HALF;
    frame_en = 1'b1; #HALF;
    for (int i = 0; i < steps; i++) begin
      logic b;
      b = 1'($urandom);
      if (tx) begin
        pcm_sdi = b; adp_sdi = 1'($urandom);
        if (i < n_in) begin pcm_sclk = 1'b0; pcm_hist = {pcm_hist[6:0], b}; end
        adp_sclk = 1'b0;
      end else begin
        adp_sdi = b; pcm_sdi = 1'($urandom);
        if (i < n_in) begin adp_sclk = 1'b0; adp_hist = {adp_hist[6:0], b}; end
        pcm_sclk = 1'b0;
      end
      #HALF;
      if (tx) begin
        chk(adp_sdo_oe == active, "R7/R10 adp_sdo_oe", adp_sdo_oe, active);
        chk(pcm_sdo_oe == 1'b0, "R9 pcm_sdo_oe in tx window", pcm_sdo_oe, 0);
        if (active && i < olen)
          chk(adp_sdo == oword[olen-1-i], "R7 adp_sdo bit", adp_sdo, oword[olen-1-i]);
      end else begin
        chk(pcm_sdo_oe == active, "R8/R10 pcm_sdo_oe", pcm_sdo_oe, active);
        chk(adp_sdo_oe == 1'b0, "R9 adp_sdo_oe in rx window", adp_sdo_oe, 0);
        if (active && i < olen)
          chk(pcm_sdo == oword[olen-1-i], "R8 pcm_sdo bit", pcm_sdo, oword[olen-1-i]);
      end
      pcm_sclk = 1'b1; adp_sclk = 1'b1; #HALF;
    end
    qsel = q; law_a = l; chan_en = e; chan_init = ini;
    #HALF;
    frame_en = 1'b0;
    // disturb controls after the strobe (R4)
    #1; qsel = ~q; law_a = ~l; chan_en = ~e; chan_init = ~ini;
    #HALF;
    chk(!adp_sdo_oe && !pcm_sdo_oe, "R9 oe low with window closed",
        {adp_sdo_oe, pcm_sdo_oe}, 0);

    exp_word = tx ? pcm_hist : last_bits(adp_hist, code_len(q));
    found = 0;
    for (int c = 0; c < 20 && found == 0; c++) begin
      @(negedge clk);
      if (core_valid) found = 1;
    end
    chk(found == 1, "R5 core_valid after window", found, 1);
    if (found == 1) begin
      chk(core_word == exp_word, tx ? "R1 pcm word" : "R2 adpcm word", core_word, exp_word);
      chk(core_dir_tx == tx, "R4 core_dir_tx", core_dir_tx, tx);
      chk({core_qsel, core_law_a, core_chan_en, core_chan_init} == {q, l, e, ini},
          "R4 control bits", {core_qsel, core_law_a, core_chan_en, core_chan_init},
          {q, l, e, ini});
      @(negedge clk);
      chk(core_valid == 1'b0, "R5 single-cycle valid", core_valid, 0);
    end
    if (tx) begin m_tx_pend = 0; m_tx_q = q; end
    else    m_rx_pend = 0;

    if (give_result) begin
      w = 8'($urandom);
      @(negedge clk);
      res_valid = 1'b1; res_dir_tx = tx; res_word = w;
      @(negedge clk);
      res_valid = 1'b0;
      if (tx) begin m_tx_pend = 1; m_tx_res = w[4:0]; end
      else    begin m_rx_pend = 1; m_rx_res = w; end
    end
    junk_edges();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!core_valid && !adp_sdo_oe && !pcm_sdo_oe, "R6 outputs in reset",
        {core_valid, adp_sdo_oe, pcm_sdo_oe}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!core_valid && !adp_sdo_oe && !pcm_sdo_oe, "R6 outputs after reset",
        {core_valid, adp_sdo_oe, pcm_sdo_oe}, 0);

    // directed corners
    run_window(1'b1, 0, 8, 1'b1);   // R1 full word, no result pending yet
    run_window(1'b0, 3, 5, 1'b1);   // R2 five-bit code
    run_window(1'b0, 1, 4, 1'b0);   // R8 output of pending result, R2 four-bit
    run_window(1'b0, 2, 0, 1'b0);   // R10 nothing pending; R2/R3 no edges -> history
    run_window(1'b1, 3, 10, 1'b1);  // R7 output, R1 last eight of ten
    run_window(1'b1, 0, 3, 1'b0);   // R7 five-bit output; R1 partial word
    run_window(1'b1, 1, 8, 1'b0);   // R10 tx not pending
    // random mix
    for (int k = 0; k < 40; k++)
      run_window(1'($urandom), -1, -1, 1'($urandom_range(0, 3) != 0));
    summary();
    $finish;
  end
endmodule